// File: doc/BRIEF.md
# Supply and Pushbutton Reset Controller

This block generates the reset for a processor from two causes: a digital flag that reports the main supply as below its minimum tolerance, and an active-low pushbutton. A supply fault forces reset on the next clock edge. The pushbutton is first brought into the clock domain by a two-stage synchronizer, then filtered so that contact bounce has no effect. The block also holds reset by itself while its own power-on reset is active.

When the last cause goes away, one shared stretch timer keeps reset active for a fixed number of clock cycles. For the button, that interval starts from the debounced release, not from the press. If either cause returns while the timer runs, the timer reloads and the full interval starts again. Reset is available in both polarities. Both outputs come straight from registers, so they never glitch. All intervals are parameters counted in clock cycles. The defaults give about 130 ms of stretch and 10 ms of debounce at 125 MHz.

Top module: `supply_reset_ctrl`

## Requirements
- R1: When `supply_low_i` is 1 at a rising edge, `sys_rst_o` is 1 after that edge.
- R2: After the supply flag drops, reset stays active and deasserts at the (STRETCH_CYCLES+1)-th rising edge at which no cause is present, provided no cause returns.
- R3: While `rst` is 1, `sys_rst_o` is 1. After `rst` is released with no cause present, reset deasserts at the (STRETCH_CYCLES+1)-th rising edge that follows.
- R4: A button press is a low level on `btn_n_i`. With reset idle, a press held steadily asserts `sys_rst_o` at the (DEBOUNCE_CYCLES+3)-th rising edge after the input falls.
- R5: A low or high pulse on `btn_n_i` shorter than DEBOUNCE_CYCLES cycles is ignored and does not assert reset.
- R6: After a long press, reset deasserts at the (DEBOUNCE_CYCLES+STRETCH_CYCLES+3)-th rising edge after `btn_n_i` returns high.
- R7: A cause that reappears while reset is being stretched reloads the timer. Reset then deasserts at the (STRETCH_CYCLES+1)-th edge after the last cause clears, including when the button and supply causes overlap.
- R8: `sys_rst_n_o` is always the exact complement of `sys_rst_o`. Both are register outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset of the block |
| supply_low_i | input | 1 | 1 when the main supply is below tolerance; synchronous to clk |
| btn_n_i | input | 1 | Pushbutton, active low, asynchronous |
| sys_rst_o | output | 1 | Processor reset, active high |
| sys_rst_n_o | output | 1 | Processor reset, active low |

## Verification
The assertions assume that `supply_low_i` is already synchronous to `clk`, since it goes straight into the cause logic with no synchronizer. They also assume `rst` is held for at least one edge at start-up, so every register has a defined value before any property is checked. The bench changes both inputs only on falling edges, so the supply flag always meets setup. Its button pulses are long enough that the synchronizer sees each level on at least one edge, and they are chosen to fall either clearly below or clearly above the debounce limit.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  // Phase of the shared stretch timer.
  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_HOLD    = 2'd1,
    PH_STRETCH = 2'd2
  } rst_phase_e;

  // Defaults sized for a 125 MHz clock.
  localparam int unsigned DEF_STRETCH_CYCLES  = 16_250_000;
  localparam int unsigned DEF_DEBOUNCE_CYCLES = 1_250_000;
  localparam int unsigned DEF_SYNC_STAGES     = 2;

endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RESET_VAL;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RESET_VAL;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

  // R4: the last stage only moves to a value the stage before it already held.
  a_r4_sync_follows: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (dout == $past(chain_q[(STAGES > 1) ? STAGES-2 : 0])));

endmodule

// File: rtl/rc_debounce.sv
module rc_debounce #(
  parameter int unsigned STABLE_CYCLES = 8,
  parameter logic        RESET_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= RESET_VAL;
    end else if (din == level_q) begin
      run_q   <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      level_q <= din;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  assign dout = level_q;

  // R5: the run counter never reaches the acceptance length.
  a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
    run_q < CW'(STABLE_CYCLES));

  // R5: the accepted level only changes after a full run of a differing input.
  a_r5_change_after_run: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> ($past(run_q) == LAST && $past(din) == level_q));

endmodule

// File: rtl/rc_stretch.sv
module rc_stretch
  import supply_rst_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic active_o,
  output logic active_n_o
);

  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYCLES);

  logic [CW-1:0] left_q;
  rst_phase_e    phase_q;
  logic          act_q;
  logic          act_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= FULL;
      phase_q <= PH_STRETCH;
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
    end else if (cause) begin
      left_q  <= FULL;
      phase_q <= PH_HOLD;
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
      phase_q <= PH_STRETCH;
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
    end else begin
      phase_q <= PH_RUN;
      act_q   <= 1'b0;
      act_n_q <= 1'b1;
    end
  end

  assign active_o   = act_q;
  assign active_n_o = act_n_q;

  // R8: the two output registers never agree.
  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    act_q != act_n_q);

  // R2: release only after the timer has drained with no cause present.
  a_r2_no_early_release: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> ($past(left_q) == '0 && !$past(cause)));

  // R7: any cause reloads the full interval.
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    cause |=> (left_q == FULL && phase_q == PH_HOLD));

  // R2: the timer never holds more than the full interval.
  a_r2_bound: assert property (@(posedge clk) disable iff (rst)
    left_q <= FULL);

  // R3: only the idle phase may show reset released.
  a_r3_idle_only: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> phase_q == PH_RUN);

endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
  import supply_rst_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES  = DEF_STRETCH_CYCLES,
  parameter int unsigned DEBOUNCE_CYCLES = DEF_DEBOUNCE_CYCLES,
  parameter int unsigned SYNC_STAGES     = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic btn_n_i,
  output logic sys_rst_o,
  output logic sys_rst_n_o
);

  logic btn_sync;
  logic btn_clean_n;
  logic cause;

  rc_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_n_i),
    .dout (btn_sync)
  );

  rc_debounce #(
    .STABLE_CYCLES (DEBOUNCE_CYCLES),
    .RESET_VAL     (1'b1)
  ) i_debounce (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_sync),
    .dout (btn_clean_n)
  );

  assign cause = supply_low_i | ~btn_clean_n;

  rc_stretch #(
    .STRETCH_CYCLES (STRETCH_CYCLES)
  ) i_stretch (
    .clk        (clk),
    .rst        (rst),
    .cause      (cause),
    .active_o   (sys_rst_o),
    .active_n_o (sys_rst_n_o)
  );

  // R1: a supply fault shows on the reset output at the next edge.
  a_r1_supply_immediate: assert property (@(posedge clk) disable iff (rst)
    supply_low_i |=> sys_rst_o);

  // R6: an accepted button press keeps reset active at the next edge.
  a_r6_button_holds: assert property (@(posedge clk) disable iff (rst)
    !btn_clean_n |=> (sys_rst_o && !sys_rst_n_o));

endmodule

// File: tb/test_supply_reset_ctrl.sv
module test_supply_reset_ctrl;

  localparam int unsigned STR = 40;
  localparam int unsigned DEB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic btn_n = 1'b1;
  logic sys_rst;
  logic sys_rst_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  supply_reset_ctrl #(
    .STRETCH_CYCLES  (STR),
    .DEBOUNCE_CYCLES (DEB),
    .SYNC_STAGES     (2)
  ) i_supply_reset_ctrl (
    .clk          (clk),
    .rst          (rst),
    .supply_low_i (supply_low),
    .btn_n_i      (btn_n),
    .sys_rst_o    (sys_rst),
    .sys_rst_n_o  (sys_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts rising edges until sys_rst reaches the wanted level.
  task automatic edges_until(input bit want, output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (sys_rst != want && n < 2000);
  endtask

  task automatic t_power_on;
    int n;
    @(negedge clk);
    rst = 1'b1;
    cyc(5);
    chk(sys_rst == 1'b1, "R3", sys_rst, 1);
    chk(sys_rst_n == ~sys_rst, "R8", sys_rst_n, ~sys_rst);
    rst = 1'b0;
    edges_until(1'b0, n);
    chk(n == STR + 1, "R3", n, STR + 1);
    chk(sys_rst_n == 1'b1, "R8", sys_rst_n, 1);
  endtask

  task automatic t_supply;
    int n;
    supply_low = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(sys_rst == 1'b1, "R1", sys_rst, 1);
    chk(sys_rst_n == 1'b0, "R8", sys_rst_n, 0);
    cyc(5);
    supply_low = 1'b0;
    edges_until(1'b0, n);
    chk(n == STR + 1, "R2", n, STR + 1);
  endtask

  task automatic t_press;
    int n;
    btn_n = 1'b0;
    edges_until(1'b1, n);
    chk(n == DEB + 3, "R4", n, DEB + 3);
    cyc(20);
    btn_n = 1'b1;
    edges_until(1'b0, n);
    chk(n == DEB + STR + 3, "R6", n, DEB + STR + 3);
    chk(sys_rst_n == 1'b1, "R8", sys_rst_n, 1);
  endtask

  task automatic t_bounce;
    int seen = 0;
    btn_n = 1'b0;
    cyc(DEB - 2);
    btn_n = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
    chk(seen == 0, "R5", seen, 0);
    seen = 0;
    for (int r = 0; r < 6; r++) begin
      btn_n = 1'b0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (sys_rst) seen++; end
      btn_n = 1'b1;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (sys_rst) seen++; end
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sys_rst) seen++;
    end
    chk(seen == 0, "R5", seen, 0);
  endtask

  task automatic t_retrigger;
    int n;
    supply_low = 1'b1;
    cyc(1);
    supply_low = 1'b0;
    cyc(25);
    chk(sys_rst == 1'b1, "R7", sys_rst, 1);
    supply_low = 1'b1;
    cyc(1);
    supply_low = 1'b0;
    edges_until(1'b0, n);
    chk(n == STR + 1, "R7", n, STR + 1);
  endtask

  task automatic t_overlap;
    int n;
    btn_n = 1'b0;
    cyc(15);
    supply_low = 1'b1;
    cyc(3);
    btn_n = 1'b1;
    cyc(20);
    chk(sys_rst == 1'b1, "R7", sys_rst, 1);
    supply_low = 1'b0;
    edges_until(1'b0, n);
    chk(n == STR + 1, "R7", n, STR + 1);
  endtask

  initial begin
    t_power_on();
    t_supply();
    cyc(3);
    t_press();
    cyc(3);
    t_bounce();
    t_retrigger();
    cyc(3);
    t_overlap();
    cyc(3);
    t_power_on();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule